// File: doc/BRIEF.md
# Programmable Down-Counting Timer

This block is one down-counting timer that software drives through a small word-addressed register bus. The counter steps down once per prescaler tick and supports three behaviours at zero: it can wrap to all ones, reload from a stored value, or stop until software loads a new count. Software can narrow it to a low slice of its width. Software sets the count in one of two ways. The immediate load register replaces the count at once and also sets the reload value. The background load register changes only the reload value and leaves the current count alone.

Each time the count arrives at zero it sets a sticky event flag. That flag shows in a raw status word and, gated by an enable bit, in a masked status word. The same gated value drives the level-sensitive `irq_o` line. Writing the clear word drops the flag.

A three-state machine tracks progress. IDLE means the enable bit is low and the count is frozen. RUN means the timer is enabled and counting. DONE means a single-shot count has reached zero and is parked. The transitions are: IDLE to RUN when enabled, and RUN to IDLE when disabled. IDLE or RUN goes to DONE when a single-shot count arrives at zero. DONE goes to RUN, or to IDLE if disabled, on an immediate load write.

Top module: `cdt_timer`

## Requirements
- R1: Word offsets are 0 immediate load, 1 live count (read only), 2 control, 3 event clear (reads zero), 4 raw status (bit 0), 5 masked status (bit 0), 6 background load, 7 reserved (reads zero, writes ignored). Control reads back bits 7,6,5,3,2,1,0 as written, and bit 4 reads zero.
- R2: A write to offset 0 replaces the count on the next edge and also sets the reload value. Offsets 0 and 6 read back the reload value.
- R3: A write to offset 6 sets only the reload value. The count is untouched, and the next reload uses the new value.
- R4: Control bits 3:2 set the step spacing: 00 every cycle, 01 every 16 cycles, 10 every 256 cycles, and 11 every cycle. The divider restarts whenever bit 7 is low.
- R5: With control bit 1 set the full counter width counts; with it clear only the low NARROW_W bits count and are read.
- R6: Free-running mode (bits 6 and 0 both clear) steps from zero to the all-ones value of the selected width.
- R7: Periodic mode (bit 6 set, bit 0 clear) steps from zero to the reload value.
- R8: Single-shot mode (bit 0 set, which wins over bit 6) parks at zero once it arrives there and stays parked until offset 0 is written.
- R9: Each step from one to zero sets the raw flag, whether or not the interrupt is enabled.
- R10: Any write to offset 3 clears the raw flag. If a zero arrival occurs in the same cycle, the flag stays set.
- R11: The masked status and `irq_o` equal the raw flag ANDed with control bit 5.
- R12: While control bit 7 is low the count holds its value.
- R13: After reset the control word, count, reload value and raw flag are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | High for a write, low for a read |
| bus_addr | input | 3 | Word offset |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data for the addressed word |
| irq_o | output | 1 | Level interrupt: raw flag gated by enable |

## Verification
The bench builds the timer with a 16-bit counter and an 8-bit narrow slice, keeping the prescale exponents at 4 and 8. With these values both the narrow wrap to 0xFF and the full-width wrap to 0xFFFF can be watched directly. The divide-by-256 spacing also fits in a few hundred cycles. A behavioural model predicts the addressed read word and the interrupt line on every clock. This covers back-to-back clear writes that race against zero arrivals, as well as single-shot parking with both mode bits set.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    typedef enum logic [2:0] {
        OFS_LOAD   = 3'd0,
        OFS_VALUE  = 3'd1,
        OFS_CTRL   = 3'd2,
        OFS_ICLR   = 3'd3,
        OFS_RAW    = 3'd4,
        OFS_MSK    = 3'd5,
        OFS_BGLOAD = 3'd6,
        OFS_RSVD   = 3'd7
    } reg_ofs_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } run_state_e;

    typedef enum logic [1:0] {
        PS_DIV1   = 2'b00,
        PS_DIV16  = 2'b01,
        PS_DIV256 = 2'b10,
        PS_RSVD   = 2'b11
    } prescale_e;

    typedef enum logic [1:0] {
        CM_FREE   = 2'd0,
        CM_RELOAD = 2'd1,
        CM_SINGLE = 2'd2
    } cnt_mode_e;

    typedef struct packed {
        logic      enable;
        logic      periodic;
        logic      irq_en;
        prescale_e prescale;
        logic      wide;
        logic      oneshot;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_word(input logic [7:0] w);
        ctrl_t c;
        c.enable   = w[7];
        c.periodic = w[6];
        c.irq_en   = w[5];
        c.prescale = prescale_e'(w[3:2]);
        c.wide     = w[1];
        c.oneshot  = w[0];
        return c;
    endfunction

    function automatic logic [7:0] ctrl_to_word(input ctrl_t c);
        return {c.enable, c.periodic, c.irq_en, 1'b0, c.prescale, c.wide, c.oneshot};
    endfunction

    // single-shot bit takes precedence over the periodic bit
    function automatic cnt_mode_e mode_of(input ctrl_t c);
        if (c.oneshot)       return CM_SINGLE;
        else if (c.periodic) return CM_RELOAD;
        else                 return CM_FREE;
    endfunction

endpackage

// File: rtl/cdt_regbank.sv
module cdt_regbank
    import cdt_pkg::*;
#(
    parameter int BUS_W = 32,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [2:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0] count_view,
    input  logic [CNT_W-1:0] reload_view,
    input  logic             zero_evt,
    output logic             cnt_enable,
    output logic             cnt_wide,
    output cnt_mode_e        cnt_mode,
    output prescale_e        pre_sel,
    output logic             load_we,
    output logic             bg_we,
    output logic [CNT_W-1:0] wdata_cnt,
    output logic             irq_o
);

    ctrl_t    ctrl_q;
    logic     raw_q;
    logic     wr_en;
    logic     ctrl_we;
    logic     clr_we;
    reg_ofs_e ofs;

    always_comb begin
        ofs     = reg_ofs_e'(bus_addr);
        wr_en   = bus_sel & bus_wr;
        ctrl_we = wr_en && (ofs == OFS_CTRL);
        clr_we  = wr_en && (ofs == OFS_ICLR);
        load_we = wr_en && (ofs == OFS_LOAD);
        bg_we   = wr_en && (ofs == OFS_BGLOAD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q <= ctrl_from_word(bus_wdata[7:0]);
        end
    end

    // a zero arrival outranks a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q <= 1'b0;
        end else if (zero_evt) begin
            raw_q <= 1'b1;
        end else if (clr_we) begin
            raw_q <= 1'b0;
        end
    end

    always_comb begin
        cnt_enable = ctrl_q.enable;
        cnt_wide   = ctrl_q.wide;
        cnt_mode   = mode_of(ctrl_q);
        pre_sel    = ctrl_q.prescale;
        wdata_cnt  = bus_wdata[CNT_W-1:0];
        irq_o      = raw_q & ctrl_q.irq_en;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (ofs)
            OFS_LOAD, OFS_BGLOAD: bus_rdata[CNT_W-1:0] = reload_view;
            OFS_VALUE:            bus_rdata[CNT_W-1:0] = count_view;
            OFS_CTRL:             bus_rdata[7:0]       = ctrl_to_word(ctrl_q);
            OFS_RAW:              bus_rdata[0]         = raw_q;
            OFS_MSK:              bus_rdata[0]         = raw_q & ctrl_q.irq_en;
            OFS_ICLR, OFS_RSVD:   bus_rdata            = '0;
        endcase
    end

    // R9: a zero arrival is always recorded
    a_r9_event_sets_raw: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt |=> raw_q);

    // R10: a clear without a competing arrival drops the flag
    a_r10_clear_drops_raw: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !zero_evt) |=> !raw_q);

endmodule

// File: rtl/cdt_prescale.sv
module cdt_prescale
    import cdt_pkg::*;
#(
    parameter int PRE_MID_LG = 4,
    parameter int PRE_HI_LG  = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run,
    input  prescale_e sel,
    output logic      tick
);

    localparam logic [PRE_HI_LG-1:0] LAST_MID = PRE_HI_LG'((1 << PRE_MID_LG) - 1);
    localparam logic [PRE_HI_LG-1:0] LAST_HI  = '1;

    logic [PRE_HI_LG-1:0] pre_q;
    logic [PRE_HI_LG-1:0] last;

    always_comb begin
        case (sel)
            PS_DIV16:  last = LAST_MID;
            PS_DIV256: last = LAST_HI;
            default:   last = '0;
        endcase
        tick = run && (pre_q >= last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!run || tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // R4: a dividing setting never produces ticks on adjacent cycles
    a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (sel == PS_DIV16 || sel == PS_DIV256))
            |=> (!tick || sel == PS_DIV1 || sel == PS_RSVD));

endmodule

// File: rtl/cdt_counter.sv
module cdt_counter
    import cdt_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int NARROW_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             wide,
    input  cnt_mode_e        mode,
    input  logic             tick,
    input  logic             load_we,
    input  logic             bg_we,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] reload_o,
    output logic             zero_evt
);

    localparam logic [CNT_W-1:0] NARROW_MASK = CNT_W'((64'd1 << NARROW_W) - 64'd1);
    localparam logic [CNT_W-1:0] ONE         = CNT_W'(1);

    run_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q, reload_q;
    logic [CNT_W-1:0] width_mask, count_eff;
    logic             step, arrive;

    always_comb begin
        width_mask = wide ? '1 : NARROW_MASK;
        count_eff  = count_q & width_mask;
        step       = tick && (state_q != ST_DONE);
        arrive     = step && !load_we && (count_eff == ONE);
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (arrive && mode == CM_SINGLE) state_d = ST_DONE;
                else if (enable)                 state_d = ST_RUN;
            end
            ST_RUN: begin
                if (arrive && mode == CM_SINGLE) state_d = ST_DONE;
                else if (!enable)                state_d = ST_IDLE;
            end
            ST_DONE: begin
                if (load_we) state_d = enable ? ST_RUN : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // count and reload registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q  <= '0;
            reload_q <= '0;
        end else begin
            if (load_we || bg_we) reload_q <= wdata;
            if (load_we) begin
                count_q <= wdata;
            end else if (step) begin
                if (count_eff != '0) begin
                    count_q <= (count_eff - ONE) & width_mask;
                end else begin
                    unique case (mode)
                        CM_FREE:   count_q <= width_mask;
                        CM_RELOAD: count_q <= reload_q & width_mask;
                        default:   count_q <= count_q;
                    endcase
                end
            end
        end
    end

    always_comb begin
        count_o  = count_eff;
        reload_o = reload_q;
        zero_evt = arrive;
    end

    // R2: an immediate load lands on the next edge
    a_r2_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
        load_we |=> count_q == $past(wdata));

    // R6: free-running wraps to all ones of the active width
    a_r6_free_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load_we && count_eff == '0 && mode == CM_FREE)
            |=> count_q == $past(width_mask));

    // R7: periodic mode takes the reload value at zero
    a_r7_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load_we && count_eff == '0 && mode == CM_RELOAD)
            |=> count_q == $past(reload_q & width_mask));

    // R8: a parked single-shot count stays parked
    a_r8_done_parks: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && !load_we) |=> (state_q == ST_DONE && count_q == $past(count_q)));

    // R12: nothing moves while disabled
    a_r12_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !load_we) |=> count_q == $past(count_q));

endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
    import cdt_pkg::*;
#(
    parameter int BUS_W      = 32,
    parameter int CNT_W      = 32,
    parameter int NARROW_W   = 16,
    parameter int PRE_MID_LG = 4,
    parameter int PRE_HI_LG  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [2:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             irq_o
);

    logic             cnt_enable, cnt_wide, load_we, bg_we, zero_evt, tick;
    cnt_mode_e        cnt_mode;
    prescale_e        pre_sel;
    logic [CNT_W-1:0] wdata_cnt, count_view, reload_view;

    cdt_regbank #(
        .BUS_W (BUS_W),
        .CNT_W (CNT_W)
    ) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .count_view  (count_view),
        .reload_view (reload_view),
        .zero_evt    (zero_evt),
        .cnt_enable  (cnt_enable),
        .cnt_wide    (cnt_wide),
        .cnt_mode    (cnt_mode),
        .pre_sel     (pre_sel),
        .load_we     (load_we),
        .bg_we       (bg_we),
        .wdata_cnt   (wdata_cnt),
        .irq_o       (irq_o)
    );

    cdt_prescale #(
        .PRE_MID_LG (PRE_MID_LG),
        .PRE_HI_LG  (PRE_HI_LG)
    ) pre_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (cnt_enable),
        .sel   (pre_sel),
        .tick  (tick)
    );

    cdt_counter #(
        .CNT_W    (CNT_W),
        .NARROW_W (NARROW_W)
    ) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (cnt_enable),
        .wide     (cnt_wide),
        .mode     (cnt_mode),
        .tick     (tick),
        .load_we  (load_we),
        .bg_we    (bg_we),
        .wdata    (wdata_cnt),
        .count_o  (count_view),
        .reload_o (reload_view),
        .zero_evt (zero_evt)
    );

    // R11: the masked status word agrees with the interrupt line
    a_r11_masked_matches_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_MSK) |-> (bus_rdata == BUS_W'(irq_o)));

endmodule

// File: tb/cdt_timer_tb_top.sv
module cdt_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [2:0]  addr = 3'd1;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int    vectors = 0;
    int    miss = 0;
    string phase = "R13";

    always #5 clk = ~clk;

    cdt_timer #(
        .BUS_W      (32),
        .CNT_W      (16),
        .NARROW_W   (8),
        .PRE_MID_LG (4),
        .PRE_HI_LG  (8)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (sel),
        .bus_wr    (wr),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq_o     (irq)
    );

    // behavioural reference
    logic [7:0]  m_ctrl;
    logic [15:0] m_count, m_reload;
    logic        m_raw, m_done;
    int          m_pre;

    always @(posedge clk) begin
        int          div;
        logic        tk, stp, arr, ldw, bgw, clw, ctw;
        logic [15:0] msk, eff;
        if (!rst_n) begin
            m_ctrl <= 8'h00; m_count <= 16'h0; m_reload <= 16'h0;
            m_raw <= 1'b0; m_done <= 1'b0; m_pre <= 0;
        end else begin
            div = (m_ctrl[3:2] == 2'b01) ? 16 : (m_ctrl[3:2] == 2'b10) ? 256 : 1;
            tk  = m_ctrl[7] && (m_pre >= div - 1);
            m_pre <= (!m_ctrl[7] || tk) ? 0 : m_pre + 1;
            msk = m_ctrl[1] ? 16'hFFFF : 16'h00FF;
            eff = m_count & msk;
            ldw = sel && wr && addr == 3'd0;
            bgw = sel && wr && addr == 3'd6;
            clw = sel && wr && addr == 3'd3;
            ctw = sel && wr && addr == 3'd2;
            stp = tk && !m_done;
            arr = stp && !ldw && eff == 16'd1;
            if (ldw) begin
                m_count <= wdata[15:0];
                m_done  <= 1'b0;
            end else if (stp) begin
                if (eff != 16'd0)   m_count <= eff - 16'd1;
                else if (m_ctrl[0]) m_count <= m_count;
                else if (m_ctrl[6]) m_count <= m_reload & msk;
                else                m_count <= msk;
                if (arr && m_ctrl[0]) m_done <= 1'b1;
            end
            if (ldw || bgw) m_reload <= wdata[15:0];
            if (arr)      m_raw <= 1'b1;
            else if (clw) m_raw <= 1'b0;
            if (ctw) m_ctrl <= wdata[7:0] & 8'hEF;
        end
    end

    function automatic logic [31:0] m_read(input logic [2:0] a);
        logic [15:0] msk;
        msk = m_ctrl[1] ? 16'hFFFF : 16'h00FF;
        case (a)
            3'd0, 3'd6: return {16'h0, m_reload};
            3'd1:       return {16'h0, m_count & msk};
            3'd2:       return {24'h0, m_ctrl};
            3'd4:       return {31'h0, m_raw};
            3'd5:       return {31'h0, m_raw & m_ctrl[5]};
            default:    return 32'h0;
        endcase
    endfunction

    // per-clock comparison of the addressed word and the interrupt line
    always @(negedge clk) begin
        if (rst_n) begin
            vectors++;
            if (rdata !== m_read(addr) || irq !== (m_raw & m_ctrl[5])) begin
                miss++;
                $display("FAIL %s per-cycle addr %0d: got rdata=%h irq=%b expected rdata=%h irq=%b",
                         phase, addr, rdata, irq, m_read(addr), m_raw & m_ctrl[5]);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(posedge clk); #2;
        sel = 1'b0; wr = 1'b0; addr = 3'd1;
    endtask

    task automatic hold_write(input logic [2:0] a, input logic [31:0] d, input int n);
        @(posedge clk); #2;
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        repeat (n) @(posedge clk);
        #2;
        sel = 1'b0; wr = 1'b0; addr = 3'd1;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(posedge clk); #2;
        sel = 1'b1; wr = 1'b0; addr = a;
        @(negedge clk);
        d = rdata;
        @(posedge clk); #2;
        sel = 1'b0; addr = 3'd1;
    endtask

    task automatic wait_count(input logic [31:0] v);
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            if (rdata === v) break;
        end
    endtask

    task automatic wait_irq();
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            if (irq === 1'b1) break;
        end
    endtask

    task automatic step_gap(output int gap);
        logic [31:0] prev;
        int          n;
        @(negedge clk);
        prev = rdata;
        n = 0;
        while (rdata === prev && n < 2000) begin @(negedge clk); n++; end
        prev = rdata;
        gap = 0;
        while (rdata === prev && gap < 2000) begin @(negedge clk); gap++; end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miss);
    endtask

    initial begin : wdog
        repeat (100000) @(posedge clk);
        miss++; vectors++;
        $display("FAIL R13 watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        int          g;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        phase = "R13";
        bus_read(3'd2, d); chk("R13 ctrl after reset", d, 32'h0);
        bus_read(3'd1, d); chk("R13 count after reset", d, 32'h0);
        bus_read(3'd4, d); chk("R13 raw after reset", d, 32'h0);

        phase = "R1";
        bus_write(3'd2, 32'h0000_003E);
        bus_read(3'd2, d); chk("R1 control readback", d, 32'h0000_002E);
        bus_write(3'd7, 32'hFFFF_FFFF);
        bus_read(3'd7, d); chk("R1 reserved reads zero", d, 32'h0);
        bus_write(3'd3, 32'hFFFF_FFFF);
        bus_read(3'd3, d); chk("R1 clear word reads zero", d, 32'h0);
        bus_write(3'd2, 32'h0);

        phase = "R2";
        bus_write(3'd0, 32'h0000_1234);
        bus_read(3'd1, d); chk("R2 R5 narrow count after load", d, 32'h0000_0034);
        bus_read(3'd0, d); chk("R2 reload from load", d, 32'h0000_1234);
        bus_write(3'd2, 32'h0000_0002);
        bus_read(3'd1, d); chk("R5 wide count view", d, 32'h0000_1234);

        phase = "R3";
        bus_write(3'd6, 32'h0000_0055);
        bus_read(3'd1, d); chk("R3 count untouched", d, 32'h0000_1234);
        bus_read(3'd0, d); chk("R3 reload updated", d, 32'h0000_0055);

        phase = "R12";
        repeat (20) @(posedge clk);
        bus_read(3'd1, d); chk("R12 disabled hold", d, 32'h0000_1234);

        phase = "R7";
        bus_write(3'd0, 32'd5);
        bus_write(3'd2, 32'h0000_00E2);
        wait_irq();
        chk("R9 irq raised", {31'h0, irq}, 32'h1);
        @(negedge clk); chk("R7 reload after zero", rdata, 32'd5);
        bus_write(3'd6, 32'd9);
        wait_count(32'd0);
        @(negedge clk); chk("R3 R7 background reload used", rdata, 32'd9);
        bus_read(3'd5, d); chk("R11 masked set", d, 32'h1);

        phase = "R10";
        hold_write(3'd3, 32'h1, 7);
        bus_write(3'd0, 32'd1);
        hold_write(3'd3, 32'h1, 9);
        bus_write(3'd2, 32'h0000_0022);
        bus_write(3'd3, 32'h1);
        bus_read(3'd4, d); chk("R10 clear drops raw", d, 32'h0);
        chk("R10 irq low after clear", {31'h0, irq}, 32'h0);

        phase = "R9";
        bus_write(3'd0, 32'd2);
        bus_write(3'd2, 32'h0000_0082);
        wait_count(32'd0);
        @(negedge clk); chk("R6 R5 wide wrap", rdata, 32'h0000_FFFF);
        bus_read(3'd4, d); chk("R9 raw without enable", d, 32'h1);
        bus_read(3'd5, d); chk("R11 masked clear when disabled", d, 32'h0);
        chk("R11 irq low", {31'h0, irq}, 32'h0);

        phase = "R6";
        bus_write(3'd2, 32'h0);
        bus_write(3'd0, 32'd2);
        bus_write(3'd2, 32'h0000_0080);
        wait_count(32'd0);
        @(negedge clk); chk("R6 R5 narrow wrap", rdata, 32'h0000_00FF);

        phase = "R4";
        bus_write(3'd2, 32'h0);
        bus_write(3'd0, 32'h0000_8000);
        bus_write(3'd2, 32'h0000_0086);
        step_gap(g); chk("R4 divide by 16", g, 32'd16);
        bus_write(3'd2, 32'h0);
        bus_write(3'd2, 32'h0000_008A);
        step_gap(g); chk("R4 divide by 256", g, 32'd256);
        bus_write(3'd2, 32'h0);
        bus_write(3'd2, 32'h0000_008E);
        step_gap(g); chk("R4 reserved code divides by 1", g, 32'd1);
        bus_write(3'd2, 32'h0000_0082);
        step_gap(g); chk("R4 divide by 1", g, 32'd1);

        phase = "R8";
        bus_write(3'd2, 32'h0);
        bus_write(3'd3, 32'h1);
        bus_write(3'd0, 32'd3);
        bus_write(3'd2, 32'h0000_0081);
        wait_count(32'd0);
        repeat (10) @(negedge clk);
        chk("R8 parked at zero", rdata, 32'h0);
        bus_write(3'd2, 32'h0000_00C1);
        repeat (10) @(negedge clk);
        chk("R8 single-shot wins over periodic", rdata, 32'h0);
        bus_write(3'd0, 32'd2);
        wait_count(32'd1);
        chk("R8 load restarts count", rdata, 32'd1);
        wait_count(32'd0);
        bus_read(3'd4, d); chk("R8 R9 restart arrival flagged", d, 32'h1);

        repeat (4) @(posedge clk);
        summary();
        $finish;
    end

endmodule